// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives two to four parallel synchronous buck channels from one shared period counter. Each active phase runs the same switching period, but its cycle begins at its own offset. The offsets are spread evenly across the period according to how many phases are in use. As a result, the combined ripple of the channels repeats N times per period. A single digital duty command sets the high-side on-time of every phase. That on-time is scaled to the period and limited to three quarters of it.

The number of active phases is learned when the block is enabled. It comes from two strap inputs that tell whether the current-sense connection of phase 2 or phase 3 is left open. A phase at or above the first open sense stays idle. Protection logic can raise an over-voltage trip at any time. From then on, every active phase is held with its low-side switch on until the block is disabled. While disabled, all outputs carry the idle code.

Top module: `mpwm_gen`

## Requirements
- R1: Each phase output is a 2-bit code at bits [2k+1:2k] of `phase_code`: 2'b10 means high-side on, 2'b01 means low-side on and 2'b00 means idle. Call E0 the rising edge that first samples `enable` high after it was low. The output registered at the (j+1)-th edge after E0 corresponds to period position j mod PERIOD.
- R2: At E0 the active count N is captured. N = 2 if `sense_open[2]` is 1; otherwise N = 3 if `sense_open[3]` is 1; otherwise N = 4. N does not change until `enable` goes low, even if `sense_open` changes.
- R3: Phase k (k < N) begins its cycle at period position k*PERIOD/N.
- R4: At phase position p within its own cycle, the phase shows high-side on when p < H and low-side on otherwise. H = floor(duty*PERIOD/1024).
- R5: H is limited to 3*PERIOD/4. With PERIOD = 240, a duty of 1023 gives 180 high cycles per period.
- R6: A phase captures `duty_cmd` only at position 0 of its own cycle. A change of `duty_cmd` at any other time does not affect the current cycle of that phase. Before its first cycle start after E0, a phase shows low-side on.
- R7: Phases with index k >= N stay idle (2'b00) while running.
- R8: When `ovp_trip` is sampled high while running, every active phase shows low-side on from the next edge on. This holds until `enable` goes low, even after `ovp_trip` falls.
- R9: After reset, and from the first edge that samples `enable` low, every phase code is idle. The E0 edge itself also registers idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; a rising level restarts the period and re-detects N |
| sense_open | input | NPH-2 (2) | Bit i set: current sense of phase i is left open |
| duty_cmd | input | DW (10) | Duty command, full scale 1024 |
| ovp_trip | input | 1 | Over-voltage trip from protection logic |
| phase_code | output | 2*NPH (8) | Per-phase drive codes, phase k at [2k+1:2k] |

## Verification
A wrong phase count or offset table shows up as a phase code that rises at the wrong position. This appears within one period after E0, so the bench compares every phase on every cycle against a position model. A lost duty latch or a missing clamp changes the length of a high interval in the first full cycle of the affected phase. A crowbar latch that does not hold shows up as a high-side code one cycle after `ovp_trip` falls. Stale on-times that survive a disable appear as a high code before the phase's first cycle start in the next run.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } phase_code_e;
endpackage

// File: rtl/mpwm_count_detect.sv
module mpwm_count_detect #(
    parameter int NPH = 4,
    parameter int NW  = $clog2(NPH + 1)
) (
    input  logic [NPH-1:2] sense_open,
    output logic [NW-1:0]  count
);
    // The lowest open sense input above phase 1 sets the count.
    always_comb begin
        count = NW'(NPH);
        for (int k = NPH - 1; k >= 2; k--) begin
            if (sense_open[k]) count = NW'(k);
        end
    end
endmodule

// File: rtl/mpwm_duty_scale.sv
module mpwm_duty_scale #(
    parameter int PERIOD = 240,
    parameter int DW     = 10,
    parameter int CW     = $clog2(PERIOD),
    parameter int CLAMP  = (PERIOD * 3) / 4
) (
    input  logic [DW-1:0] duty,
    output logic [CW-1:0] hi_cycles
);
    localparam int PRW = DW + CW + 1;

    logic [PRW-1:0] prod;
    logic [PRW-1:0] scaled;

    always_comb begin
        prod   = PRW'(duty) * PRW'(PERIOD);
        scaled = prod >> DW;
        if (scaled > PRW'(CLAMP)) hi_cycles = CW'(CLAMP);
        else                      hi_cycles = CW'(scaled);
    end
endmodule

// File: rtl/mpwm_phase_slice.sv
module mpwm_phase_slice
    import mpwm_pkg::*;
#(
    parameter int PERIOD = 240,
    parameter int CW     = $clog2(PERIOD),
    parameter int OW     = CW + 2,
    parameter int CLAMP  = (PERIOD * 3) / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          active,
    input  logic          force_low,
    input  logic [CW-1:0] cnt,
    input  logic [OW-1:0] offset,
    input  logic [CW-1:0] hi_new,
    output logic [1:0]    code
);
    typedef struct packed {
        logic [CW-1:0] hi;
        phase_code_e   code;
    } slice_st_t;

    slice_st_t s_d, s_q;
    logic [OW-1:0] cnt_x;
    logic [OW-1:0] pos;
    logic [CW-1:0] hi_use;

    always_comb begin
        s_d   = s_q;
        cnt_x = OW'(cnt);
        if (cnt_x >= offset) pos = cnt_x - offset;
        else                 pos = cnt_x + OW'(PERIOD) - offset;
        hi_use = (pos == '0) ? hi_new : s_q.hi;

        if (!run) begin
            s_d.hi   = '0;
            s_d.code = PH_IDLE;
        end else begin
            s_d.hi = hi_use;
            if (!active)                   s_d.code = PH_IDLE;
            else if (force_low)            s_d.code = PH_LOW;
            else if (pos < OW'(hi_use))    s_d.code = PH_HIGH;
            else                           s_d.code = PH_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hi   <= '0;
            s_q.code <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign code = s_q.code;

    // Checker: length of the current high-side run.
    logic [CW:0] hrun_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hrun_q <= '0;
        else if (s_q.code == PH_HIGH) hrun_q <= hrun_q + 1'b1;
        else                          hrun_q <= '0;
    end

    a_r5_high_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code == PH_HIGH) |-> (hrun_q < (CW+1)'(CLAMP)));

    a_r7_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (s_q.code == PH_IDLE));
endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen
    import mpwm_pkg::*;
#(
    parameter int NPH    = 4,
    parameter int PERIOD = 240,
    parameter int DW     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [NPH-1:2]   sense_open,
    input  logic [DW-1:0]    duty_cmd,
    input  logic             ovp_trip,
    output logic [2*NPH-1:0] phase_code
);
    localparam int CW    = $clog2(PERIOD);
    localparam int NW    = $clog2(NPH + 1);
    localparam int OW    = $clog2(NPH * PERIOD) + 1;
    localparam int CLAMP = (PERIOD * 3) / 4;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic [NW-1:0] nph;
        logic          ovp;
    } top_st_t;

    top_st_t s_d, s_q;
    logic [NW-1:0] det_count;
    logic [CW-1:0] hi_cycles;
    logic          run_go;
    logic          force_low;

    mpwm_count_detect #(.NPH(NPH), .NW(NW)) u_detect (
        .sense_open (sense_open),
        .count      (det_count)
    );

    mpwm_duty_scale #(.PERIOD(PERIOD), .DW(DW), .CW(CW), .CLAMP(CLAMP)) u_scale (
        .duty      (duty_cmd),
        .hi_cycles (hi_cycles)
    );

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
            s_d.ovp = 1'b0;
        end else if (!s_q.run) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
            s_d.nph = det_count;
            s_d.ovp = 1'b0;
        end else begin
            s_d.cnt = (s_q.cnt == CW'(PERIOD - 1)) ? '0 : s_q.cnt + 1'b1;
            if (ovp_trip) s_d.ovp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.run <= 1'b0;
            s_q.nph <= NW'(NPH);
            s_q.ovp <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_go    = s_q.run & enable;
    assign force_low = s_q.ovp | ovp_trip;

    for (genvar k = 0; k < NPH; k++) begin : g_phase
        logic [OW-1:0] off_k;
        logic          act_k;

        always_comb begin
            off_k = '0;
            for (int n = 2; n <= NPH; n++) begin
                if (32'(s_q.nph) == n) off_k = OW'((k * PERIOD) / n);
            end
            act_k = (32'(s_q.nph) > k);
        end

        mpwm_phase_slice #(.PERIOD(PERIOD), .CW(CW), .OW(OW), .CLAMP(CLAMP)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_go),
            .active    (act_k),
            .force_low (force_low),
            .cnt       (s_q.cnt),
            .offset    (off_k),
            .hi_new    (hi_cycles),
            .code      (phase_code[2*k +: 2])
        );
    end

    logic any_high;
    always_comb begin
        any_high = 1'b0;
        for (int k = 0; k < NPH; k++) begin
            if (phase_code[2*k +: 2] == PH_HIGH) any_high = 1'b1;
        end
    end

    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CW'(PERIOD));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && enable) |=> $stable(s_q.nph));

    a_r8_crowbar: assert property (@(posedge clk) disable iff (!rst_n)
        (run_go && force_low && enable) |=> !any_high);

    a_r9_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (phase_code == '0));
endmodule

// File: tb/mpwm_gen_test.sv
module mpwm_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:2] sense_open = 2'b00;
    logic [9:0] duty_cmd = '0;
    logic       ovp_trip = 1'b0;
    logic [7:0] phase_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int n_m;
    int c_m;
    int hi_m [4];
    bit ovp_m;

    always #2 clk = ~clk;

    mpwm_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sense_open (sense_open),
        .duty_cmd   (duty_cmd),
        .ovp_trip   (ovp_trip),
        .phase_code (phase_code)
    );

    function automatic int clampv(int d);
        int v = (d * 240) / 1024;
        return (v > 180) ? 180 : v;
    endfunction

    function automatic int count_of(logic [3:2] s);
        if (s[2]) return 2;
        if (s[3]) return 3;
        return 4;
    endfunction

    task automatic check_all_idle(string tag);
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (phase_code[2*k +: 2] !== 2'b00) begin
                errors++;
                $display("FAIL %s phase %0d actual %b expected 00", tag, k, phase_code[2*k +: 2]);
            end
        end
    endtask

    // One cycle of the reference model and a compare on all phases.
    task automatic step_check(string tag);
        @(posedge clk);
        #1;
        if (ovp_trip) ovp_m = 1;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] exp;
            int off;
            int pos;
            if (k >= n_m) begin
                exp = 2'b00;
            end else begin
                off = (k * 240) / n_m;
                pos = (c_m - off + 240) % 240;
                if (pos == 0) hi_m[k] = clampv(int'(duty_cmd));
                if (ovp_m)              exp = 2'b01;
                else if (pos < hi_m[k]) exp = 2'b10;
                else                    exp = 2'b01;
            end
            checks++;
            if (phase_code[2*k +: 2] !== exp) begin
                errors++;
                $display("FAIL %s phase %0d pos %0d actual %b expected %b", tag, k, c_m,
                         phase_code[2*k +: 2], exp);
            end
        end
        c_m = (c_m + 1) % 240;
    endtask

    task automatic run_cycles(int n, string tag);
        for (int i = 0; i < n; i++) step_check(tag);
    endtask

    task automatic start_run(logic [3:2] s, logic [9:0] d);
        @(negedge clk);
        sense_open = s;
        duty_cmd   = d;
        enable     = 1'b1;
        @(posedge clk);
        #1;
        n_m = count_of(s);
        c_m = 0;
        ovp_m = 0;
        for (int k = 0; k < 4; k++) hi_m[k] = 0;
        check_all_idle("R9 E0 edge");
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk);
        #1;
        check_all_idle("R9 disable");
        repeat (3) @(posedge clk);
        #1;
        check_all_idle("R9 disabled hold");
    endtask

    task automatic t_reset();
        #1;
        check_all_idle("R9 reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_all_idle("R9 after reset");
    endtask

    task automatic t_four_phase();
        start_run(2'b00, 10'd512);
        run_cycles(500, "R3 R4 R1 four phases");
        stop_run();
    endtask

    task automatic t_three_phase();
        start_run(2'b10, 10'd300);
        run_cycles(500, "R2 R3 R7 three phases");
        stop_run();
    endtask

    task automatic t_two_phase_clamp();
        start_run(2'b01, 10'd1023);
        run_cycles(500, "R5 R7 two phases clamp");
        stop_run();
    endtask

    task automatic t_duty_latch();
        start_run(2'b00, 10'd256);
        run_cycles(100, "R6 before change");
        @(negedge clk);
        duty_cmd = 10'd768;
        run_cycles(300, "R6 after change");
        @(negedge clk);
        duty_cmd = 10'd0;
        run_cycles(260, "R4 zero duty");
        stop_run();
    endtask

    task automatic t_count_hold();
        start_run(2'b00, 10'd400);
        run_cycles(50, "R2 before strap change");
        @(negedge clk);
        sense_open = 2'b01;
        run_cycles(300, "R2 strap ignored while running");
        stop_run();
        start_run(2'b01, 10'd400);
        run_cycles(260, "R2 redetect on enable");
        stop_run();
    endtask

    task automatic t_crowbar();
        start_run(2'b10, 10'd900);
        run_cycles(90, "R8 before trip");
        @(negedge clk);
        ovp_trip = 1'b1;
        step_check("R8 trip cycle");
        @(negedge clk);
        ovp_trip = 1'b0;
        run_cycles(300, "R8 latched");
        stop_run();
        start_run(2'b00, 10'd900);
        run_cycles(250, "R8 cleared by disable");
        stop_run();
    endtask

    initial begin
        t_reset();
        t_four_phase();
        t_three_phase();
        t_two_phase_clamp();
        t_duty_latch();
        t_count_hold();
        t_crowbar();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule